// File: doc/BRIEF.md
# MSI Message Capture Queue

This block takes inbound message-signalled interrupt writes and stores each one as a 16-byte record in a circular buffer in system memory. It then holds a level interrupt toward the host until software has drained the buffer. A host driver programs a 64-bit buffer base and a control word through a small word-addressed register port. It reads the producer position from the write offset register. After it consumes records, it hands back its consumer position through the read offset register.

The buffer size is a power of two between 32 KB and 256 KB, selected by a two-bit field. Offsets are byte offsets that stay 16-byte aligned and below the selected size. When the buffer fills, one of three things happens. The block can refuse new messages (back-pressure on the inbound port). It can drop the oldest record by pushing the read offset forward. With full detection off, it can simply keep writing. Only one memory write is outstanding at a time. The write offset moves only after the memory side acknowledges the record.

Top module: `msi_capture_queue`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the control word, the base address and both offsets to zero. After that edge, `irq_o`, `mem_req` and `msi_ready` read 0.
- R2: Register word addresses are 0 control, 3 base high, 4 base low, 5 read offset and 6 write offset. `reg_rdata` holds the value at `reg_addr` one clock after a cycle with `reg_rd` high. Control reads back only bits 0, 1, 3, 4, 9 and 8, so writing all ones reads back 0x31B. Writes to offset 6 are ignored. Unmapped offsets read 0.
- R3: With control bit 0 (enable) set, an MSI taken on `msi_valid && msi_ready` raises `mem_req`, with `mem_addr` equal to base + write offset. The 128-bit `mem_data` carries the low 16 bits of `msi_data` in bits 15:0, with byte k at bits 8k+7:8k, and every other bit is zero. The request and its address and data hold until the clock that samples `mem_ack`.
- R4: The write offset advances by 16 only on the clock that samples `mem_ack` with `mem_req` high. It wraps to 0 at 2^(sel+15) bytes, where sel is control bits 9:8.
- R5: A value written to the read offset register is stored ANDed with the mask (size − 1) with the low 4 bits cleared.
- R6: `irq_o` is a register. At each clock it takes (enable AND control bit 3) AND (read offset ≠ write offset), using the values held before that clock.
- R7: The buffer is full when (write offset + 16) mod size equals the read offset and control bit 1 (full detection) is set. If control bit 4 (stop-when-full) is also set, `msi_ready` is low while the buffer is full.
- R8: If full detection is set and stop-when-full is clear, an MSI taken while full is still written. On its acknowledge the read offset also advances by 16, modulo size, dropping the oldest record.
- R9: With full detection clear, capture continues through any number of wraps and the read offset is never changed by the block.
- R10: Clearing enable while a record write is pending lets that write complete and advance the write offset. After that, `msi_ready` stays low.
- R11: `msi_ready` is low while a record write is pending, so at most one write is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data, valid the clock after `reg_rd` |
| msi_valid | input | 1 | Inbound MSI write present |
| msi_data | input | 32 | MSI data word (low 16 bits are the interrupt number) |
| msi_ready | output | 1 | MSI accepted when high together with `msi_valid` |
| mem_req | output | 1 | Record write request |
| mem_addr | output | 64 | Byte address of the record |
| mem_data | output | 128 | Record payload, little-endian |
| mem_ack | input | 1 | Memory has taken the record |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The checker relies on three things about the inputs. `mem_ack` is only raised while `mem_req` is high, and for one clock per request. Software does not rewrite the size field while records are queued. Reset is held high from time zero until the first clock edge has passed. The bench drives these through its memory responder, which acks a request once and then drops `mem_ack` the clock after. It also reprograms the size only from the reset state and starts with reset asserted. Inbound messages are held on `msi_valid` until `msi_ready` is seen before a rising edge. Refusal is tested by holding `msi_valid` over several clocks and observing that no request appears.

// File: rtl/msi_cq_pkg.sv
package msi_cq_pkg;

  localparam int REC_BYTES = 16;
  localparam int REC_W     = REC_BYTES * 8;
  localparam int MIN_LOG2  = 15;

  localparam logic [2:0] RA_CTRL    = 3'd0;
  localparam logic [2:0] RA_BASE_HI = 3'd3;
  localparam logic [2:0] RA_BASE_LO = 3'd4;
  localparam logic [2:0] RA_RD_OFF  = 3'd5;
  localparam logic [2:0] RA_WR_OFF  = 3'd6;

  localparam int CB_EN   = 0;
  localparam int CB_FDET = 1;
  localparam int CB_IRQ  = 3;
  localparam int CB_STOP = 4;
  localparam int CB_SIZE = 8;

  typedef struct packed {
    logic [1:0] size_sel;
    logic       stop_full;
    logic       irq_en;
    logic       full_det;
    logic       enable;
  } ctrl_t;

endpackage

// File: rtl/msi_cq_regs.sv
module msi_cq_regs
  import msi_cq_pkg::*;
#(
  parameter int OFF_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  input  logic             reg_rd,
  output logic [31:0]      reg_rdata,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [OFF_W-1:0] rd_off,
  output ctrl_t            ctrl,
  output logic [63:0]      base,
  output logic             rd_we,
  output logic [OFF_W-1:0] rd_wval
);

  logic [31:0] base_hi_q;
  logic [31:0] base_lo_q;
  logic [31:0] rd_mux;

  assign base    = {base_hi_q, base_lo_q};
  assign rd_we   = reg_wr && (reg_addr == RA_RD_OFF);
  assign rd_wval = reg_wdata[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      base_hi_q <= '0;
      base_lo_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_CTRL: begin
          ctrl.enable    <= reg_wdata[CB_EN];
          ctrl.full_det  <= reg_wdata[CB_FDET];
          ctrl.irq_en    <= reg_wdata[CB_IRQ];
          ctrl.stop_full <= reg_wdata[CB_STOP];
          ctrl.size_sel  <= reg_wdata[CB_SIZE +: 2];
        end
        RA_BASE_HI: base_hi_q <= reg_wdata;
        RA_BASE_LO: base_lo_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_CTRL: begin
        rd_mux[CB_EN]        = ctrl.enable;
        rd_mux[CB_FDET]      = ctrl.full_det;
        rd_mux[CB_IRQ]       = ctrl.irq_en;
        rd_mux[CB_STOP]      = ctrl.stop_full;
        rd_mux[CB_SIZE +: 2] = ctrl.size_sel;
      end
      RA_BASE_HI: rd_mux = base_hi_q;
      RA_BASE_LO: rd_mux = base_lo_q;
      RA_RD_OFF:  rd_mux[OFF_W-1:0] = rd_off;
      RA_WR_OFF:  rd_mux[OFF_W-1:0] = wr_off;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/msi_cq_ptr.sv
module msi_cq_ptr
  import msi_cq_pkg::*;
#(
  parameter int OFF_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       size_sel,
  input  logic             full_det,
  input  logic             stop_full,
  input  logic             adv,
  input  logic             rd_we,
  input  logic [OFF_W-1:0] rd_wval,
  output logic [OFF_W-1:0] wr_off,
  output logic [OFF_W-1:0] rd_off,
  output logic             full
);

  localparam int STEP_LOG2 = $clog2(REC_BYTES);
  localparam logic [OFF_W-1:0] STEP = OFF_W'(REC_BYTES);

  logic [OFF_W-1:0] mask;
  logic [OFF_W-1:0] wr_next;
  logic [OFF_W-1:0] rd_next;
  logic             overrun;

  // Mask keeps bits from the record size up to (size_sel + MIN_LOG2 - 1).
  for (genvar gi = 0; gi < OFF_W; gi++) begin : g_mask
    assign mask[gi] = (gi >= STEP_LOG2) && (gi < (int'(size_sel) + MIN_LOG2));
  end

  assign wr_next = (wr_off + STEP) & mask;
  assign rd_next = (rd_off + STEP) & mask;
  assign full    = full_det && (wr_next == rd_off);
  assign overrun = full && !stop_full;

  always_ff @(posedge clk) begin
    if (rst) wr_off <= '0;
    else if (adv) wr_off <= wr_next;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_off <= '0;
    else if (rd_we) rd_off <= rd_wval & mask;
    else if (adv && overrun) rd_off <= rd_next;
  end

endmodule

// File: rtl/msi_cq_writer.sv
module msi_cq_writer
  import msi_cq_pkg::*;
#(
  parameter int OFF_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             refuse,
  input  logic [63:0]      base,
  input  logic [OFF_W-1:0] wr_off,
  input  logic             msi_valid,
  input  logic [31:0]      msi_data,
  output logic             msi_ready,
  output logic             mem_req,
  output logic [63:0]      mem_addr,
  output logic [REC_W-1:0] mem_data,
  input  logic             mem_ack,
  output logic             adv
);

  typedef enum logic {ST_IDLE, ST_WAIT} st_t;
  st_t state;

  logic take;

  assign msi_ready = (state == ST_IDLE) && enable && !refuse;
  assign take      = msi_valid && msi_ready;
  assign adv       = (state == ST_WAIT) && mem_ack;
  assign mem_req   = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (take) state <= ST_WAIT;
        ST_WAIT: if (mem_ack) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_data <= '0;
    end else if (take) begin
      mem_addr <= base + 64'(wr_off);
      mem_data <= {{(REC_W-16){1'b0}}, msi_data[15:0]};
    end
  end

endmodule

// File: rtl/msi_capture_queue.sv
module msi_capture_queue
  import msi_cq_pkg::*;
#(
  parameter int OFF_W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   reg_addr,
  input  logic         reg_wr,
  input  logic [31:0]  reg_wdata,
  input  logic         reg_rd,
  output logic [31:0]  reg_rdata,
  input  logic         msi_valid,
  input  logic [31:0]  msi_data,
  output logic         msi_ready,
  output logic         mem_req,
  output logic [63:0]  mem_addr,
  output logic [127:0] mem_data,
  input  logic         mem_ack,
  output logic         irq_o
);

  ctrl_t            ctrl;
  logic [63:0]      base;
  logic             rd_we;
  logic [OFF_W-1:0] rd_wval;
  logic [OFF_W-1:0] wr_off;
  logic [OFF_W-1:0] rd_off;
  logic             full;
  logic             adv;
  logic             refuse;

  assign refuse = full && ctrl.stop_full;

  msi_cq_regs #(.OFF_W(OFF_W)) i_regs (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .wr_off(wr_off), .rd_off(rd_off),
    .ctrl(ctrl), .base(base), .rd_we(rd_we), .rd_wval(rd_wval)
  );

  msi_cq_ptr #(.OFF_W(OFF_W)) i_ptr (
    .clk(clk), .rst(rst),
    .size_sel(ctrl.size_sel), .full_det(ctrl.full_det),
    .stop_full(ctrl.stop_full), .adv(adv),
    .rd_we(rd_we), .rd_wval(rd_wval),
    .wr_off(wr_off), .rd_off(rd_off), .full(full)
  );

  msi_cq_writer #(.OFF_W(OFF_W)) i_writer (
    .clk(clk), .rst(rst),
    .enable(ctrl.enable), .refuse(refuse),
    .base(base), .wr_off(wr_off),
    .msi_valid(msi_valid), .msi_data(msi_data), .msi_ready(msi_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ack(mem_ack), .adv(adv)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= ctrl.enable && ctrl.irq_en && (rd_off != wr_off);
  end

endmodule

// File: rtl/msi_cq_checker.sv
module msi_cq_checker #(
  parameter int OFF_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             msi_ready,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [63:0]      mem_addr,
  input logic [127:0]     mem_data,
  input logic [OFF_W-1:0] wr_off,
  input logic [OFF_W-1:0] rd_off,
  input logic             full,
  input logic             stop_full,
  input logic             irq_o
);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

  assert_rec_format_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_data[127:16] == '0));

  assert_wr_on_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_off != $past(wr_off)) |-> $past(mem_req && mem_ack));

  assert_wr_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_off[3:0] == 4'd0));

  assert_irq_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_off == wr_off) |=> !irq_o);

  assert_stop_full_R7: assert property (@(posedge clk) disable iff (rst)
    (full && stop_full) |-> !msi_ready);

  assert_one_pending_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !msi_ready);

endmodule

bind msi_capture_queue msi_cq_checker #(.OFF_W(OFF_W)) i_chk (
  .clk(clk), .rst(rst), .msi_ready(msi_ready),
  .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_data(mem_data),
  .wr_off(wr_off), .rd_off(rd_off),
  .full(full), .stop_full(ctrl.stop_full), .irq_o(irq_o)
);

// File: tb/test_msi_capture_queue.sv
module test_msi_capture_queue;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic         reg_rd = 1'b0;
  logic [31:0]  reg_rdata;
  logic         msi_valid = 1'b0;
  logic [31:0]  msi_data = '0;
  logic         msi_ready;
  logic         mem_req;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;
  logic         mem_ack = 1'b0;
  logic         irq_o;

  int errors = 0;
  int checks = 0;
  int rec_cnt = 0;
  logic         ack_en = 1'b1;
  logic [63:0]  last_addr = '0;
  logic [127:0] last_data = '0;

  localparam logic [63:0] BASE = 64'h0000_0001_8000_0000;

  always #10 clk = ~clk;

  msi_capture_queue i_msi_capture_queue (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .msi_valid(msi_valid), .msi_data(msi_data), .msi_ready(msi_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ack(mem_ack), .irq_o(irq_o)
  );

  // Memory responder: one-clock ack per request, logs each record.
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req && ack_en) begin
      mem_ack   = 1'b1;
      rec_cnt   = rec_cnt + 1;
      last_addr = mem_addr;
      last_data = mem_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic send_msi(input logic [31:0] d);
    @(negedge clk); msi_valid = 1'b1; msi_data = d; #1;
    while (!msi_ready) begin @(negedge clk); #1; end
    @(negedge clk); msi_valid = 1'b0;
  endtask

  task automatic send_done(input logic [31:0] d);
    send_msi(d);
    repeat (3) @(negedge clk);
  endtask

  // Holds an MSI for n clocks; returns whether it was ever taken.
  task automatic try_msi(input logic [31:0] d, input int n, output bit taken);
    taken = 1'b0;
    @(negedge clk); msi_valid = 1'b1; msi_data = d;
    for (int i = 0; i < n; i++) begin
      #1; if (msi_ready) taken = 1'b1;
      @(negedge clk);
    end
    msi_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    #1;
    chk(irq_o == 1'b0 && mem_req == 1'b0 && msi_ready == 1'b0, "R1 outputs",
        {irq_o, mem_req, msi_ready}, 0);
    reg_read(3'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    reg_read(3'd4, v); chk(v == 0, "R1 base lo", v, 0);
    reg_read(3'd5, v); chk(v == 0, "R1 rd off", v, 0);
    reg_read(3'd6, v); chk(v == 0, "R1 wr off", v, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    reg_write(3'd0, 32'hFFFF_FFFF);
    reg_read(3'd0, v); chk(v == 32'h31B, "R2 ctrl bits", v, 32'h31B);
    reg_write(3'd0, 32'h0);
    reg_write(3'd3, 32'h0000_0001); reg_write(3'd4, 32'h8000_0000);
    reg_read(3'd3, v); chk(v == 32'h1, "R2 base hi", v, 1);
    reg_read(3'd4, v); chk(v == 32'h8000_0000, "R2 base lo", v, 32'h8000_0000);
    reg_write(3'd6, 32'h0000_0100);
    reg_read(3'd6, v); chk(v == 0, "R2 wr off write ignored", v, 0);
    reg_write(3'd1, 32'h1234_5678);
    reg_read(3'd1, v); chk(v == 0, "R2 unmapped", v, 0);
    reg_write(3'd5, 32'h0001_2345);
    reg_read(3'd5, v); chk(v == 32'h2340, "R5 mask 32KB", v, 32'h2340);
    reg_write(3'd0, 32'h300);
    reg_write(3'd5, 32'h0001_2345);
    reg_read(3'd5, v); chk(v == 32'h12340, "R5 mask 256KB", v, 32'h12340);
    do_reset();
  endtask

  task automatic t_capture();
    logic [31:0] v;
    reg_write(3'd3, BASE[63:32]); reg_write(3'd4, BASE[31:0]);
    reg_write(3'd0, 32'h009);
    send_done(32'hABCD_1234);
    chk(last_addr == BASE, "R3 first addr", last_addr, BASE);
    chk(last_data == 128'h1234, "R3 payload low16", last_data, 128'h1234);
    reg_read(3'd6, v); chk(v == 32'h10, "R4 wr step", v, 32'h10);
    chk(irq_o == 1'b1, "R6 irq asserted", irq_o, 1);
    send_done(32'h0000_FFFF);
    chk(last_addr == BASE + 64'h10, "R3 second addr", last_addr, BASE + 64'h10);
    chk(last_data == 128'hFFFF, "R3 payload second", last_data, 128'hFFFF);
    reg_write(3'd5, 32'h20);
    @(negedge clk);
    chk(irq_o == 1'b0, "R6 irq drained", irq_o, 0);
    send_done(32'h5);
    reg_write(3'd0, 32'h001);
    @(negedge clk);
    chk(irq_o == 1'b0, "R6 irq disabled", irq_o, 0);
    do_reset();
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    int start;
    reg_write(3'd3, BASE[63:32]); reg_write(3'd4, BASE[31:0]);
    reg_write(3'd0, 32'h001);
    start = rec_cnt;
    for (int i = 0; i < 2048; i++) send_msi(i);
    repeat (3) @(negedge clk);
    chk(rec_cnt - start == 2048, "R9 all captured", rec_cnt - start, 2048);
    chk(last_addr == BASE + 64'h7FF0, "R4 last slot", last_addr, BASE + 64'h7FF0);
    reg_read(3'd6, v); chk(v == 0, "R4 wrap to zero", v, 0);
    reg_read(3'd5, v); chk(v == 0, "R9 rd untouched", v, 0);
    do_reset();
  endtask

  task automatic t_stop_full();
    logic [31:0] v;
    bit taken;
    int start;
    reg_write(3'd0, 32'h013);
    reg_write(3'd5, 32'h40);
    for (int i = 0; i < 3; i++) send_done(i);
    start = rec_cnt;
    try_msi(32'h77, 6, taken);
    repeat (2) @(negedge clk);
    chk(!taken && rec_cnt == start, "R7 refused when full", taken, 0);
    reg_read(3'd6, v); chk(v == 32'h30, "R7 wr held", v, 32'h30);
    reg_write(3'd5, 32'h50);
    send_done(32'h77);
    reg_read(3'd6, v); chk(v == 32'h40, "R7 resumes", v, 32'h40);
    do_reset();
  endtask

  task automatic t_overwrite();
    logic [31:0] v;
    reg_write(3'd0, 32'h003);
    reg_write(3'd5, 32'h40);
    for (int i = 0; i < 3; i++) send_done(i);
    send_done(32'h99);
    chk(last_addr == 64'h30, "R8 written while full", last_addr, 64'h30);
    reg_read(3'd6, v); chk(v == 32'h40, "R8 wr advanced", v, 32'h40);
    reg_read(3'd5, v); chk(v == 32'h50, "R8 oldest dropped", v, 32'h50);
    do_reset();
  endtask

  task automatic t_disable_inflight();
    logic [31:0] v;
    bit taken;
    int start;
    reg_write(3'd0, 32'h001);
    ack_en = 1'b0;
    start = rec_cnt;
    send_msi(32'h42);
    #1;
    chk(mem_req == 1'b1 && msi_ready == 1'b0, "R11 one pending",
        {mem_req, msi_ready}, 2'b10);
    reg_write(3'd0, 32'h000);
    ack_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(rec_cnt == start + 1, "R10 pending completes", rec_cnt, start + 1);
    reg_read(3'd6, v); chk(v == 32'h10, "R10 wr advanced", v, 32'h10);
    try_msi(32'h43, 4, taken);
    chk(!taken, "R10 stopped after disable", taken, 0);
    do_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_capture();
    t_wrap();
    t_stop_full();
    t_overwrite();
    t_disable_inflight();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule